// File: doc/BRIEF.md
# Control Command Decoder with Pin Set/Clear

This block sits behind a host register write and turns each 6-bit command code into one action. Four codes give each of two general-purpose output pins its own set and clear command. The host can therefore move one pin without reading the other back and without keeping a private copy of the pin states. Two further codes ask an attached codec to start or to enter power-save. Those two requests are blocked when the generic-codec mode input is high, because no codec-specific control applies in that mode.

The host presents a code together with a one-cycle strobe. All outputs are registered. Pin levels change, and the start, power-save and bad-code pulses appear, on the clock edge that samples the strobe. Each pulse lasts exactly one cycle. Any code without a meaning, whether it lies below the codec-start code or in the reserved range above the last pin code, changes nothing and raises only the bad-code pulse.

Top module: `cmd_port_decoder`

## Requirements
- R1: While `rst` is high at a clock edge, `pin_a`, `pin_b`, `start_pulse`, `psave_pulse` and `bad_code` are all 0 after that edge.
- R2: A strobed code 0x09 makes `pin_a` 0 after the sampling edge, and `pin_b` keeps its value.
- R3: A strobed code 0x0A makes `pin_a` 1 after the sampling edge, and `pin_b` keeps its value.
- R4: A strobed code 0x0B makes `pin_b` 0 after the sampling edge, and `pin_a` keeps its value.
- R5: A strobed code 0x0C makes `pin_b` 1 after the sampling edge, and `pin_a` keeps its value.
- R6: A strobed code 0x07 with `generic_mode` low makes `start_pulse` high for exactly the one cycle after the sampling edge, with no pin change.
- R7: A strobed code 0x08 with `generic_mode` low makes `psave_pulse` high for exactly the one cycle after the sampling edge, with no pin change.
- R8: With `generic_mode` high, strobed codes 0x07 and 0x08 produce no start or power-save pulse, no bad-code pulse and no pin change.
- R9: A strobed code in 0x00–0x06 or 0x0D–0x3F raises `bad_code` for one cycle and changes no pin and no other pulse. This holds whatever the level of `generic_mode`.
- R10: In a cycle without a strobe, the next cycle shows both pins unchanged and all three pulses low.
- R11: At most one of `start_pulse`, `psave_pulse` and `bad_code` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle strobe marking a command write |
| cmd_code | input | 6 | Command code |
| generic_mode | input | 1 | High when a generic codec mode is selected |
| pin_a | output | 1 | First general-purpose output pin |
| pin_b | output | 1 | Second general-purpose output pin |
| start_pulse | output | 1 | One-cycle codec-start request |
| psave_pulse | output | 1 | One-cycle codec power-save request |
| bad_code | output | 1 | One-cycle flag for an unassigned or reserved code |

## Verification
The checker tests on every cycle that each pin command moves only its own pin to the commanded level. It also tests that the codec pulses follow their codes only outside generic mode, that unassigned codes touch nothing but the flag, that idle cycles are quiet, and that the pulses never overlap. The reset values, and the long-run pin state after mixed sequences, come only from the bench. The bench sweeps all 64 codes in both modes, sends back-to-back strobes and applies a reset mid-run, checking each result against its own model.

// File: rtl/ccd_pkg.sv
package ccd_pkg;

    localparam int CODE_W     = 6;
    localparam int N_PINS     = 2;
    localparam int START_CODE = 7;
    localparam int PSAVE_CODE = 8;
    localparam int PIN_BASE   = 9;
    localparam int PIN_LAST   = PIN_BASE + 2 * N_PINS - 1;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_START,
        ACT_PSAVE,
        ACT_PIN,
        ACT_BAD
    } act_kind_e;

    typedef struct packed {
        act_kind_e          kind;
        logic [N_PINS-1:0]  pin_sel;
        logic               pin_lvl;
    } cmd_act_t;

    // Pin i is cleared by PIN_BASE+2i and set by PIN_BASE+2i+1.
    function automatic cmd_act_t decode_code(input logic [CODE_W-1:0] code,
                                             input logic generic);
        cmd_act_t a;
        int       c;
        int       off;
        a.kind    = ACT_BAD;
        a.pin_sel = '0;
        a.pin_lvl = 1'b0;
        c = int'(code);
        if (c == START_CODE) begin
            a.kind = generic ? ACT_NONE : ACT_START;
        end else if (c == PSAVE_CODE) begin
            a.kind = generic ? ACT_NONE : ACT_PSAVE;
        end else if (c >= PIN_BASE && c <= PIN_LAST) begin
            off = c - PIN_BASE;
            a.kind = ACT_PIN;
            a.pin_sel[off / 2] = 1'b1;
            a.pin_lvl = (off % 2) == 1;
        end
        return a;
    endfunction

endpackage

// File: rtl/ccd_classify.sv
module ccd_classify
    import ccd_pkg::*;
(
    input  logic              cmd_valid,
    input  logic [CODE_W-1:0] cmd_code,
    input  logic              generic_mode,
    output logic              start_req,
    output logic              psave_req,
    output logic              bad_req,
    output logic [N_PINS-1:0] pin_we,
    output logic              pin_lvl
);
    cmd_act_t act;

    always_comb begin
        act = decode_code(cmd_code, generic_mode);
        if (!cmd_valid) begin
            act.kind    = ACT_NONE;
            act.pin_sel = '0;
        end
    end

    always_comb begin
        start_req = act.kind == ACT_START;
        psave_req = act.kind == ACT_PSAVE;
        bad_req   = act.kind == ACT_BAD;
        pin_we    = (act.kind == ACT_PIN) ? act.pin_sel : '0;
        pin_lvl   = act.pin_lvl;
    end
endmodule

// File: rtl/ccd_pin_bank.sv
module ccd_pin_bank
    import ccd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [N_PINS-1:0] pin_we,
    input  logic              pin_lvl,
    output logic [N_PINS-1:0] pins
);
    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        always_ff @(posedge clk) begin
            if (rst)
                pins[i] <= 1'b0;
            else if (pin_we[i])
                pins[i] <= pin_lvl;
        end
    end
endmodule

// File: rtl/ccd_pulse_gen.sv
module ccd_pulse_gen (
    input  logic clk,
    input  logic rst,
    input  logic start_req,
    input  logic psave_req,
    input  logic bad_req,
    output logic start_pulse,
    output logic psave_pulse,
    output logic bad_code
);
    always_ff @(posedge clk) begin
        if (rst) begin
            start_pulse <= 1'b0;
            psave_pulse <= 1'b0;
            bad_code    <= 1'b0;
        end else begin
            start_pulse <= start_req;
            psave_pulse <= psave_req;
            bad_code    <= bad_req;
        end
    end
endmodule

// File: rtl/cmd_port_decoder.sv
module cmd_port_decoder
    import ccd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [CODE_W-1:0] cmd_code,
    input  logic              generic_mode,
    output logic              pin_a,
    output logic              pin_b,
    output logic              start_pulse,
    output logic              psave_pulse,
    output logic              bad_code
);
    logic              start_req;
    logic              psave_req;
    logic              bad_req;
    logic [N_PINS-1:0] pin_we;
    logic              pin_lvl;
    logic [N_PINS-1:0] pins;

    ccd_classify u_classify (
        .cmd_valid    (cmd_valid),
        .cmd_code     (cmd_code),
        .generic_mode (generic_mode),
        .start_req    (start_req),
        .psave_req    (psave_req),
        .bad_req      (bad_req),
        .pin_we       (pin_we),
        .pin_lvl      (pin_lvl)
    );

    ccd_pin_bank u_pins (
        .clk     (clk),
        .rst     (rst),
        .pin_we  (pin_we),
        .pin_lvl (pin_lvl),
        .pins    (pins)
    );

    ccd_pulse_gen u_pulse (
        .clk         (clk),
        .rst         (rst),
        .start_req   (start_req),
        .psave_req   (psave_req),
        .bad_req     (bad_req),
        .start_pulse (start_pulse),
        .psave_pulse (psave_pulse),
        .bad_code    (bad_code)
    );

    assign pin_a = pins[0];
    assign pin_b = pins[1];
endmodule

// File: rtl/cmd_port_decoder_chk.sv
module cmd_port_decoder_chk (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic [5:0] cmd_code,
    input logic       generic_mode,
    input logic       pin_a,
    input logic       pin_b,
    input logic       start_pulse,
    input logic       psave_pulse,
    input logic       bad_code
);
    logic is_codec;
    logic is_rsvd;
    assign is_codec = (cmd_code == 6'h07) || (cmd_code == 6'h08);
    assign is_rsvd  = (cmd_code < 6'h07) || (cmd_code > 6'h0C);

    p_clr_a_r2: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_code == 6'h09 |=> !pin_a && $stable(pin_b));
    p_set_a_r3: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_code == 6'h0A |=> pin_a && $stable(pin_b));
    p_clr_b_r4: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_code == 6'h0B |=> !pin_b && $stable(pin_a));
    p_set_b_r5: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_code == 6'h0C |=> pin_b && $stable(pin_a));
    p_start_r6: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_code == 6'h07 && !generic_mode
        |=> start_pulse && $stable(pin_a) && $stable(pin_b));
    p_psave_r7: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_code == 6'h08 && !generic_mode
        |=> psave_pulse && $stable(pin_a) && $stable(pin_b));
    p_generic_r8: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && is_codec && generic_mode
        |=> !start_pulse && !psave_pulse && !bad_code && $stable(pin_a) && $stable(pin_b));
    p_rsvd_r9: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && is_rsvd
        |=> bad_code && !start_pulse && !psave_pulse && $stable(pin_a) && $stable(pin_b));
    p_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid
        |=> !start_pulse && !psave_pulse && !bad_code && $stable(pin_a) && $stable(pin_b));
    p_excl_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({start_pulse, psave_pulse, bad_code}));
endmodule

bind cmd_port_decoder cmd_port_decoder_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .cmd_valid    (cmd_valid),
    .cmd_code     (cmd_code),
    .generic_mode (generic_mode),
    .pin_a        (pin_a),
    .pin_b        (pin_b),
    .start_pulse  (start_pulse),
    .psave_pulse  (psave_pulse),
    .bad_code     (bad_code)
);

// File: tb/cmd_port_decoder_tb_top.sv
module cmd_port_decoder_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [5:0] cmd_code = '0;
    logic       generic_mode = 1'b0;
    logic       pin_a, pin_b, start_pulse, psave_pulse, bad_code;

    int vectors = 0;
    int misses  = 0;

    // reference model state
    bit    m_a, m_b, m_st, m_ps, m_bad;
    string m_tag = "R1";

    always #2.5 clk = ~clk;

    cmd_port_decoder dut_i (
        .clk          (clk),
        .rst          (rst),
        .cmd_valid    (cmd_valid),
        .cmd_code     (cmd_code),
        .generic_mode (generic_mode),
        .pin_a        (pin_a),
        .pin_b        (pin_b),
        .start_pulse  (start_pulse),
        .psave_pulse  (psave_pulse),
        .bad_code     (bad_code)
    );

    always @(posedge clk) begin
        int c;
        c = int'(cmd_code);
        m_st = 0; m_ps = 0; m_bad = 0;
        if (rst) begin
            m_a = 0; m_b = 0; m_tag = "R1";
        end else if (!cmd_valid) begin
            m_tag = "R10";
        end else if (c == 9)  begin m_a = 0; m_tag = "R2"; end
        else if (c == 10)     begin m_a = 1; m_tag = "R3"; end
        else if (c == 11)     begin m_b = 0; m_tag = "R4"; end
        else if (c == 12)     begin m_b = 1; m_tag = "R5"; end
        else if (c == 7 && !generic_mode) begin m_st = 1; m_tag = "R6"; end
        else if (c == 8 && !generic_mode) begin m_ps = 1; m_tag = "R7"; end
        else if (c == 7 || c == 8) begin m_tag = "R8"; end
        else begin m_bad = 1; m_tag = "R9"; end
    end

    task automatic check_one(string what, bit act, bit exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", m_tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        check_one("pin_a", pin_a, m_a);
        check_one("pin_b", pin_b, m_b);
        check_one("start_pulse", start_pulse, m_st);
        check_one("psave_pulse", psave_pulse, m_ps);
        check_one("bad_code", bad_code, m_bad);
        vectors++;
        if ($countones({start_pulse, psave_pulse, bad_code}) > 1) begin
            misses++;
            $display("FAIL R11 pulses: actual %b expected at most one high",
                     {start_pulse, psave_pulse, bad_code});
        end
    end

    task automatic send(int code, bit gen);
        @(negedge clk);
        cmd_valid    = 1'b1;
        cmd_code     = 6'(code);
        generic_mode = gen;
        @(negedge clk);
        cmd_valid    = 1'b0;
    endtask

    task automatic send_b2b(int c0, int c1, bit gen);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = 6'(c0); generic_mode = gen;
        @(negedge clk);
        cmd_code = 6'(c1);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic run_all();
        // R1: reset state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        // R3 R5 R2 R4: each pin alone
        send(10, 0); send(12, 0); send(9, 0); send(11, 0);
        send(12, 1); send(10, 1);
        // R6 R7 normal mode, R8 generic mode
        send(7, 0); send(8, 0); send(7, 1); send(8, 1);
        // R9 reserved and unassigned codes
        send(0, 0); send(6, 1); send(13, 0); send(63, 1);
        // back-to-back strobes, R11 adjacent pulses
        send_b2b(7, 8, 0);
        send_b2b(8, 40, 0);
        send_b2b(9, 10, 0);
        send_b2b(11, 12, 1);
        // full sweep in both modes
        for (int g = 0; g < 2; g++)
            for (int c = 0; c < 64; c++)
                send(c, 1'(g));
        // reset mid-run with pins high (R1)
        send(10, 0); send(12, 0);
        @(negedge clk); rst = 1'b1; cmd_valid = 1'b1; cmd_code = 6'h07;
        @(negedge clk); rst = 1'b0; cmd_valid = 1'b0;
        repeat (2) @(negedge clk);
        // mixed random traffic with idle gaps (R10)
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            cmd_valid    = ($urandom % 3) != 0;
            cmd_code     = 6'($urandom % 18);
            generic_mode = 1'($urandom % 2);
        end
        @(negedge clk); cmd_valid = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                misses++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule